// File: doc/BRIEF.md
# Mode-0 Interval Counter with Gated Terminal Output

This block is one slice of a legacy-style programmable interval timer. It has three 16-bit down-counters, and each counter is programmed over a byte-wide I/O bus. Software first writes a command byte to the command port. That byte selects a channel and also arms the channel in "interrupt on terminal count" mode. Software then writes the 16-bit count to that channel's data port as two bytes, low byte first.

After the high byte arrives, the counter takes one count off for each cycle in which the shared tick enable is asserted and the channel's gate is high. When it reaches terminal count, the channel's output rises. The output then stays high until software programs the channel again.

Channel 2 has a gate that software controls through bit 0 of a separate control/status port. Its output can be polled in bit 5 of the same port. A typical use is calibrating some other time base: software loads a known number of ticks, raises the gate, and polls bit 5 until it goes high. The gates of channels 0 and 1 are tied high. Loading zero into channel 0 makes it expire once after the longest possible interval and then go quiet, which silences it in practice.

Top module: `pit_mode0_timer`

## Requirements
- R1: After reset every channel output is 0, the channel 2 gate is 0, and the status port at 0x61 reads 0x00.
- R2: A write to 0x43 is accepted only when all of the following hold: bits [7:6] name a channel 0..2, bits [5:4] are 11 (low byte then high byte), bits [3:1] are 000 (mode 0) and bit 0 is 0 (binary). An accepted command forces that channel's output low, stops its counting, and makes the next data write a low byte. Every other command byte, such as 0xB4 or 0xF0, has no effect.
- R3: Channel n is written at 0x40+n. The first write after a command stores the low byte and halts counting. The second write loads {high, low} and starts counting. A tick in the same cycle as the high-byte write is not counted.
- R4: While counting with the gate high, the counter drops by one on each cycle with tick_en high. The output rises after exactly N such ticks for a loaded count N.
- R5: While the gate is low, ticks are ignored and the count holds.
- R6: Once high, the output stays high, even as further ticks wrap the counter. It falls again only when the channel receives an accepted command or a low-byte write.
- R7: A loaded count of 0 acts as 65536 ticks.
- R8: Port 0x61 works as follows. Bit 0 is the channel 2 gate and can be read and written. Bit 1 is a stored speaker enable that can be read and written and has no effect on counting. Bit 5 reads the channel 2 output and ignores writes. All other bits read 0.
- R9: The gates of channels 0 and 1 are always high, whatever value bit 0 of 0x61 holds.
- R10: Reads at any address other than 0x61 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Counter tick enable, one cycle per counter tick |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data for io_addr (combinational) |
| ch_out | output | 3 | Per-channel terminal-count outputs |

## Verification
Two events can land in the same clock edge: the high-byte load and a counter tick. The bench provokes this by writing the high byte with tick_en asserted in that same cycle. It then confirms that the output rises only after the full loaded number of later ticks, and not one tick early. A second overlap is tested as well: a command write arrives while channel 2 sits at terminal count with ticks still running. The bench checks that the output drops in the cycle after the write, and that an invalid command issued under the same conditions leaves the output high.

// File: rtl/pit_pkg.sv
// Shared constants and the command byte layout for the interval counter.
// Assumes an 8-bit I/O bus and 16-bit counters.
package pit_pkg;
    localparam int          COUNT_W        = 16;
    localparam logic [7:0]  ADDR_DATA_BASE = 8'h40;
    localparam logic [7:0]  ADDR_CMD       = 8'h43;
    localparam logic [7:0]  ADDR_CTRL      = 8'h61;
    localparam logic [1:0]  ACC_LO_HI      = 2'b11;
    localparam logic [2:0]  MODE_TC_INT    = 3'b000;
    localparam int          CTRL_GATE_BIT  = 0;
    localparam int          CTRL_SPK_BIT   = 1;
    localparam int          CTRL_OUT_BIT   = 5;

    // Command byte fields. The bit positions are fixed by the bus protocol.
    typedef struct packed {
        logic [1:0] sel;
        logic [1:0] access;
        logic [2:0] mode;
        logic       bcd;
    } pit_cmd_t;
endpackage

// File: rtl/pit_cmd_decode.sv
// Address and command decoder.
// Turns bus writes into per-channel arm strobes and data-write strobes.
// Assumes one write per cycle. Unsupported command encodings produce no strobe.
module pit_cmd_decode
    import pit_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic           io_wr,
    input  logic [7:0]     io_addr,
    input  logic [7:0]     io_wdata,
    output logic [NCH-1:0] cmd_arm,
    output logic [NCH-1:0] data_wr
);
    pit_cmd_t cmd;
    logic     cmd_ok;

    // Accept only low/high access, mode 0 and binary counting.
    always_comb begin
        cmd    = pit_cmd_t'(io_wdata);
        cmd_ok = io_wr && (io_addr == ADDR_CMD) && (cmd.access == ACC_LO_HI)
                 && (cmd.mode == MODE_TC_INT) && !cmd.bcd;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_dec
        // Per-channel strobes.
        assign cmd_arm[i] = cmd_ok && (cmd.sel == 2'(i));
        assign data_wr[i] = io_wr && (io_addr == ADDR_DATA_BASE + 8'(i));
    end
endmodule

// File: rtl/pit_counter.sv
// One mode-0 down-counter.
// Loads low then high byte, counts gated ticks, and raises out at terminal count.
// Assumes arm and data_wr are never active together (the decoder guarantees this).
module pit_counter
    import pit_pkg::*;
#(
    parameter int CW = COUNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          gate,
    input  logic          arm,
    input  logic          data_wr,
    input  logic [7:0]    wdata,
    output logic          out,
    output logic          running,
    output logic [CW-1:0] count
);
    localparam int HI_W = CW - 8;

    logic       hi_next;
    logic [7:0] lo_q;

    // Programming sequence, gated decrement and terminal-count output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out     <= 1'b0;
            running <= 1'b0;
            hi_next <= 1'b0;
            lo_q    <= '0;
            count   <= '0;
        end else if (arm) begin
            out     <= 1'b0;
            running <= 1'b0;
            hi_next <= 1'b0;
        end else if (data_wr) begin
            out     <= 1'b0;
            if (!hi_next) begin
                lo_q    <= wdata;
                hi_next <= 1'b1;
                running <= 1'b0;
            end else begin
                count   <= {wdata[HI_W-1:0], lo_q};
                hi_next <= 1'b0;
                running <= 1'b1;
            end
        end else if (running && gate && tick_en) begin
            count <= count - CW'(1);
            if (count == CW'(1))
                out <= 1'b1;
        end
    end
endmodule

// File: rtl/pit_ctrl_port.sv
// Control/status port at 0x61.
// Holds the gate bit and the speaker enable bit, and builds the read byte.
// Assumes the speaker bit drives nothing inside this block.
module pit_ctrl_port
    import pit_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       io_wr,
    input  logic [7:0] io_addr,
    input  logic [7:0] io_wdata,
    input  logic       mon_out,
    output logic       gate,
    output logic [7:0] status
);
    logic spk_en;

    // Writable bits of the port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate   <= 1'b0;
            spk_en <= 1'b0;
        end else if (io_wr && io_addr == ADDR_CTRL) begin
            gate   <= io_wdata[CTRL_GATE_BIT];
            spk_en <= io_wdata[CTRL_SPK_BIT];
        end
    end

    // Readable image of the port.
    always_comb begin
        status                = '0;
        status[CTRL_GATE_BIT] = gate;
        status[CTRL_SPK_BIT]  = spk_en;
        status[CTRL_OUT_BIT]  = mon_out;
    end
endmodule

// File: rtl/pit_mode0_timer.sv
// Top level: a three-channel mode-0 interval timer on a byte-wide I/O bus.
// Channel GATED_CH takes its gate from port 0x61. The other channels run ungated.
// Assumes tick_en is synchronous to clk.
module pit_mode0_timer
    import pit_pkg::*;
#(
    parameter int NCH      = 3,
    parameter int GATED_CH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_en,
    input  logic           io_wr,
    input  logic [7:0]     io_addr,
    input  logic [7:0]     io_wdata,
    output logic [7:0]     io_rdata,
    output logic [NCH-1:0] ch_out
);
    logic [NCH-1:0]              cmd_arm;
    logic [NCH-1:0]              data_wr;
    logic [NCH-1:0]              chan_gate;
    logic [NCH-1:0]              chan_run;
    logic [NCH-1:0][COUNT_W-1:0] chan_count;
    logic                        ctrl_gate;
    logic [7:0]                  status;

    pit_cmd_decode #(.NCH(NCH)) u_dec (
        .io_wr    (io_wr),
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .cmd_arm  (cmd_arm),
        .data_wr  (data_wr)
    );

    pit_ctrl_port u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_wr    (io_wr),
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .mon_out  (ch_out[GATED_CH]),
        .gate     (ctrl_gate),
        .status   (status)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        if (i == GATED_CH) begin : g_gated
            assign chan_gate[i] = ctrl_gate;
        end else begin : g_free
            assign chan_gate[i] = 1'b1;
        end
        pit_counter #(.CW(COUNT_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_en (tick_en),
            .gate    (chan_gate[i]),
            .arm     (cmd_arm[i]),
            .data_wr (data_wr[i]),
            .wdata   (io_wdata),
            .out     (ch_out[i]),
            .running (chan_run[i]),
            .count   (chan_count[i])
        );
    end

    // Read mux: only the control/status port returns data.
    always_comb begin
        io_rdata = (io_addr == ADDR_CTRL) ? status : 8'h00;
    end
endmodule

// File: rtl/pit_mode0_timer_chk.sv
// Assertion checker for pit_mode0_timer. It is attached with bind and watches channel 2.
module pit_mode0_timer_chk #(
    parameter int NCH = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  tick_en,
    input logic                  io_wr,
    input logic [7:0]            io_addr,
    input logic [7:0]            io_wdata,
    input logic [7:0]            io_rdata,
    input logic [NCH-1:0]        ch_out,
    input logic [NCH-1:0]        chan_gate,
    input logic [NCH-1:0]        chan_run,
    input logic [NCH-1:0][15:0]  chan_count
);
    logic ch2_touch;
    assign ch2_touch = io_wr && (io_addr == 8'h42 ||
                       (io_addr == 8'h43 && io_wdata[7:6] == 2'd2));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (ch_out == '0));

    // R2
    arm_drops_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == 8'h43 && io_wdata == 8'hB0) |=> !ch_out[2]);

    // R4
    tick_decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_run[2] && chan_gate[2] && tick_en && !io_wr)
        |=> (chan_count[2] == 16'($past(chan_count[2]) - 16'd1)));

    // R5
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_gate[2] && !io_wr) |=> $stable(chan_count[2]));

    // R6
    out_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_out[2] && !ch2_touch) |=> ch_out[2]);

    // R8
    status_image_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr == 8'h61) |-> (io_rdata[5] == ch_out[2] && io_rdata[7:6] == 2'b00
                                && io_rdata[4:2] == 3'b000));

    // R10
    idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr != 8'h61) |-> (io_rdata == 8'h00));
endmodule

bind pit_mode0_timer pit_mode0_timer_chk #(.NCH(NCH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .io_wr      (io_wr),
    .io_addr    (io_addr),
    .io_wdata   (io_wdata),
    .io_rdata   (io_rdata),
    .ch_out     (ch_out),
    .chan_gate  (chan_gate),
    .chan_run   (chan_run),
    .chan_count (chan_count)
);

// File: tb/tb_pit_mode0_timer.sv
module tb_pit_mode0_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       io_wr = 1'b0;
    logic [7:0] io_addr = 8'h00;
    logic [7:0] io_wdata = 8'h00;
    logic [7:0] io_rdata;
    logic [2:0] ch_out;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pit_mode0_timer dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .io_wr(io_wr),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata), .ch_out(ch_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0; io_addr = 8'h00;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic rd_check(input logic [7:0] a, input logic [7:0] exp, input string req);
        io_addr = a;
        #1;
        check(io_rdata == exp, req, io_rdata, exp);
        io_addr = 8'h00;
    endtask

    task automatic t_reset();
        check(ch_out == 3'b000, "R1", ch_out, 0);
        rd_check(8'h61, 8'h00, "R1");
    endtask

    task automatic t_basic();
        wr(8'h61, 8'h01);
        wr(8'h43, 8'hB0);
        wr(8'h42, 8'h05);
        wr(8'h42, 8'h00);
        ticks(4);
        check(ch_out[2] == 1'b0, "R4", ch_out[2], 0);
        ticks(1);
        check(ch_out[2] == 1'b1, "R4", ch_out[2], 1);
        rd_check(8'h61, 8'h21, "R8");
    endtask

    task automatic t_sticky_and_invalid();
        ticks(70);
        check(ch_out[2] == 1'b1, "R6", ch_out[2], 1);
        wr(8'h43, 8'hB4);
        wr(8'h43, 8'hF0);
        wr(8'h43, 8'h80);
        wr(8'h43, 8'hB1);
        check(ch_out[2] == 1'b1, "R2 invalid command ignored", ch_out[2], 1);
        // Command arrives while ticks keep running.
        @(negedge clk);
        tick_en = 1'b1; io_wr = 1'b1; io_addr = 8'h43; io_wdata = 8'hB0;
        @(negedge clk);
        io_wr = 1'b0; io_addr = 8'h00; tick_en = 1'b0;
        check(ch_out[2] == 1'b0, "R2 accepted command drops output", ch_out[2], 0);
        ticks(5);
        check(ch_out[2] == 1'b0, "R2 counting stopped after command", ch_out[2], 0);
    endtask

    task automatic t_gate();
        wr(8'h42, 8'h06);
        wr(8'h42, 8'h00);
        ticks(3);
        wr(8'h61, 8'h00);
        ticks(10);
        check(ch_out[2] == 1'b0, "R5 gate low holds", ch_out[2], 0);
        wr(8'h61, 8'h01);
        ticks(2);
        check(ch_out[2] == 1'b0, "R5 resumed count", ch_out[2], 0);
        ticks(1);
        check(ch_out[2] == 1'b1, "R5 terminal after resume", ch_out[2], 1);
    endtask

    task automatic t_low_byte_halt();
        wr(8'h43, 8'hB0);
        wr(8'h42, 8'h04);
        wr(8'h42, 8'h00);
        ticks(2);
        wr(8'h42, 8'h03);
        ticks(10);
        check(ch_out[2] == 1'b0, "R3 low byte halts", ch_out[2], 0);
        wr(8'h42, 8'h00);
        ticks(2);
        check(ch_out[2] == 1'b0, "R3 reload count", ch_out[2], 0);
        ticks(1);
        check(ch_out[2] == 1'b1, "R3 reload terminal", ch_out[2], 1);
        wr(8'h42, 8'h09);
        check(ch_out[2] == 1'b0, "R6 low byte drops output", ch_out[2], 0);
    endtask

    task automatic t_load_tick_collision();
        wr(8'h43, 8'hB0);
        wr(8'h42, 8'h03);
        @(negedge clk);
        tick_en = 1'b1; io_wr = 1'b1; io_addr = 8'h42; io_wdata = 8'h00;
        @(negedge clk);
        io_wr = 1'b0; io_addr = 8'h00; tick_en = 1'b0;
        ticks(2);
        check(ch_out[2] == 1'b0, "R3 load-cycle tick not counted", ch_out[2], 0);
        ticks(1);
        check(ch_out[2] == 1'b1, "R3 terminal after full count", ch_out[2], 1);
    endtask

    task automatic t_status_port();
        wr(8'h61, 8'hFF);
        rd_check(8'h61, 8'h23, "R8 writable bits and read-only out");
        wr(8'h61, 8'h02);
        rd_check(8'h61, 8'h22, "R8 speaker bit alone");
        rd_check(8'h42, 8'h00, "R10 data port reads zero");
        rd_check(8'h43, 8'h00, "R10 command port reads zero");
        wr(8'h61, 8'h01);
    endtask

    task automatic t_zero_count_ch0();
        wr(8'h61, 8'h00);
        wr(8'h43, 8'h30);
        check(ch_out[0] == 1'b0, "R2 channel 0 armed", ch_out[0], 0);
        wr(8'h40, 8'h00);
        wr(8'h40, 8'h00);
        ticks(65535);
        check(ch_out[0] == 1'b0, "R7 zero count before 65536", ch_out[0], 0);
        ticks(1);
        check(ch_out[0] == 1'b1, "R7 zero count = 65536 (R9 ungated)", ch_out[0], 1);
        check(ch_out[1] == 1'b0, "R9 channel 1 untouched", ch_out[1], 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_sticky_and_invalid();
        t_gate();
        t_low_byte_halt();
        t_load_tick_collision();
        t_status_port();
        t_zero_count_ch0();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule